// File: doc/BRIEF.md
# Loop-Timed DS3 Serial Payload Source

This block sits on the terminal-equipment side of a loop-timed DS3 link. It runs on the bit clock that the framer drives, nominally 44.736 MHz. It takes payload bytes from a ready/valid stream and shifts them out one bit per clock, most significant bit first. The block keeps no frame counter of its own. Its pacing comes entirely from two framer pulses. The end-of-frame strobe marks a frame boundary. The overhead indicator arrives one bit early and makes the block skip exactly one clock, so the framer can place its own overhead bit in that slot.

After reset the serial output is idle at 0 and the block waits for the first end-of-frame strobe, so that transmission begins on a frame boundary. If a payload bit is due and no byte is on hand, the block drives 0 and raises a sticky underflow flag. A payload-bit counter restarts at every frame boundary and is brought out to a port. Under a conforming framer it reaches 4704 in each frame.

Top module: `ds3_payload_src`

## Requirements
- R1: While reset is asserted and just after it, serOut, underflow, inReady and frameBitCnt are all 0.
- R2: Until the first clock edge that samples frameStrobe high, serOut stays 0, inReady stays 0 and frameBitCnt stays 0, whatever ohInd, inValid and inData do.
- R3: On a clock edge that samples frameStrobe high, serOut keeps its value and frameBitCnt becomes 0. The edge after that sends the first payload bit of the new frame.
- R4: On each edge that sends a payload bit, serOut takes the next bit of the current byte, most significant bit (bit 7) first, and frameBitCnt increases by exactly 1.
- R5: If ohInd is sampled high on edge k and frameStrobe is not sampled high on edge k+1, then on edge k+1 serOut and frameBitCnt both keep their values and no byte is taken.
- R6: inReady is high only while the block is running, no stall is pending, frameStrobe is low and the shift register is empty. A byte is taken exactly on an edge where inReady and inValid are both high, and its bit 7 goes out on that same edge.
- R7: On an edge that must send a bit while the shift register is empty and inValid is low, serOut becomes 0, frameBitCnt still advances, and underflow becomes 1.
- R8: underflow stays 1 until an edge that samples underflowClr high with no new underflow on that edge. A new underflow wins over the clear.
- R9: With inValid held high, an end-of-frame strobe, and overhead pulses spaced as a framer would place them, frameBitCnt reads 4704 just before the next end-of-frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock received from the framer |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-bit-wide end-of-frame pulse from the framer |
| ohInd | input | 1 | One-bit-wide overhead pulse, one bit ahead of the overhead slot |
| inData | input | BYTE_W | Payload byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | A byte is taken on this edge if inValid is high |
| underflowClr | input | 1 | Clears the sticky underflow flag |
| serOut | output | 1 | Serial payload bit toward the framer |
| underflow | output | 1 | Sticky flag: a payload bit was due and no byte was on hand |
| frameBitCnt | output | CNT_W | Payload bits sent since the last frame boundary |

## Verification
The bench builds the block with BYTE_W=8 and CNT_W=13. A 13-bit counter holds the full 4704-bit frame without wrapping, so a complete frame, with stalls spread through it, can be checked against the exact count. Random runs with a fixed seed mix sparse frame strobes, frequent overhead pulses, gaps in inValid and occasional clears. These runs reach stalls that land on byte boundaries, overhead and frame pulses on adjacent edges, and underflow and clear on the same edge.

// File: rtl/ds3src_pkg.sv
package ds3src_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic restart;   // frame boundary edge: counter to zero, output held
    logic sendBit;   // this edge emits one payload bit
    logic takeByte;  // this edge loads a new byte from the input stream
  } ctlStrobe_t;
endpackage

// File: rtl/ds3src_ctrl.sv
module ds3src_ctrl
  import ds3src_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStrobe,
  input  logic       ohInd,
  input  logic       inValid,
  input  logic       shiftEmpty,
  output ctlStrobe_t ctl,
  output logic       inReady
);
  logic running;
  logic stallPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      stallPend <= 1'b0;
    end else begin
      stallPend <= ohInd;
      if (frameStrobe) running <= 1'b1;
    end
  end

  logic sendNow;
  always_comb begin
    sendNow      = running && !stallPend && !frameStrobe;
    inReady      = sendNow && shiftEmpty;
    ctl.restart  = frameStrobe;
    ctl.sendBit  = sendNow;
    ctl.takeByte = inReady && inValid;
  end
endmodule

// File: rtl/ds3src_dp.sv
module ds3src_dp
  import ds3src_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [BYTE_W-1:0] inData,
  input  logic              underflowClr,
  output logic              shiftEmpty,
  output logic              serOut,
  output logic              underflow,
  output logic [CNT_W-1:0]  frameBitCnt
);
  localparam int PTR_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] shiftReg;
  logic [PTR_W-1:0]  bitsLeft;
  logic              starve;

  assign shiftEmpty = (bitsLeft == '0);
  assign starve     = ctl.sendBit && shiftEmpty && !ctl.takeByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      bitsLeft    <= '0;
      serOut      <= 1'b0;
      underflow   <= 1'b0;
      frameBitCnt <= '0;
    end else begin
      if (ctl.restart)      frameBitCnt <= '0;
      else if (ctl.sendBit) frameBitCnt <= frameBitCnt + 1'b1;

      if (ctl.sendBit) begin
        if (!shiftEmpty) begin
          serOut   <= shiftReg[BYTE_W-2];
          shiftReg <= shiftReg << 1;
          bitsLeft <= bitsLeft - 1'b1;
        end else if (ctl.takeByte) begin
          serOut   <= inData[BYTE_W-1];
          shiftReg <= inData[BYTE_W-2:0];
          bitsLeft <= PTR_W'(BYTE_W - 1);
        end else begin
          serOut   <= 1'b0;
        end
      end

      if (starve)            underflow <= 1'b1;
      else if (underflowClr) underflow <= 1'b0;
    end
  end
endmodule

// File: rtl/ds3_payload_src.sv
module ds3_payload_src
  import ds3src_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic              ohInd,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              underflowClr,
  output logic              serOut,
  output logic              underflow,
  output logic [CNT_W-1:0]  frameBitCnt
);
  ctlStrobe_t ctl;
  logic       shiftEmpty;

  ds3src_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .ohInd(ohInd),
    .inValid(inValid), .shiftEmpty(shiftEmpty), .ctl(ctl), .inReady(inReady)
  );

  ds3src_dp #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .underflowClr(underflowClr), .shiftEmpty(shiftEmpty), .serOut(serOut),
    .underflow(underflow), .frameBitCnt(frameBitCnt)
  );
endmodule

// File: rtl/ds3_payload_src_chk.sv
module ds3_payload_src_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStrobe,
  input logic             ohInd,
  input logic             inReady,
  input logic             underflowClr,
  input logic             serOut,
  input logic             underflow,
  input logic [CNT_W-1:0] frameBitCnt
);
  // R3: a frame boundary edge zeroes the counter and holds the output
  p_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> (frameBitCnt == '0) && $stable(serOut));

  // R5: the edge after an overhead pulse moves neither output nor counter
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ohInd ##1 !frameStrobe |=> $stable(serOut) && $stable(frameBitCnt));

  // R6: no byte is offered in the cycle of a pending stall
  p_no_ready_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    ohInd |=> !inReady);

  // R4: outside a boundary the counter holds or steps by one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> (frameBitCnt == $past(frameBitCnt)) ||
                     (frameBitCnt == $past(frameBitCnt) + 1'b1));

  // R8: the flag is sticky without a clear
  p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    underflow && !underflowClr |=> underflow);
endmodule

bind ds3_payload_src ds3_payload_src_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ds3_payload_src_tb.sv
module ds3_payload_src_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStrobe = 1'b0, ohInd = 1'b0, inValid = 1'b0, underflowClr = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inReady, serOut, underflow;
  logic [12:0] frameBitCnt;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model state
  bit       mRun = 0, mStall = 0, mOut = 0, mUf = 0;
  logic [7:0] mByte = 8'h00;
  int       mLeft = 0, mCnt = 0;

  always #5 clk = ~clk;

  ds3_payload_src u_dut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .ohInd(ohInd),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .underflowClr(underflowClr), .serOut(serOut), .underflow(underflow),
    .frameBitCnt(frameBitCnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expReadyOf(input bit fs);
    return mRun && !mStall && !fs && (mLeft == 0);
  endfunction

  // one clock: drive at negedge, predict, sample after posedge
  task automatic step(input bit fs, input bit oh, input bit v, input logic [7:0] d, input bit clr);
    bit send, take, starve;
    string req;
    @(negedge clk);
    frameStrobe = fs; ohInd = oh; inValid = v; inData = d; underflowClr = clr;
    #1;
    chk(mRun ? "R6" : "R2", "inReady", int'(inReady), int'(expReadyOf(fs)));
    send   = mRun && !mStall && !fs;
    take   = expReadyOf(fs) && v;
    starve = send && (mLeft == 0) && !take;
    if (fs) req = "R3";
    else if (!mRun) req = "R2";
    else if (mStall) req = "R5";
    else if (starve) req = "R7";
    else req = "R4";
    if (fs) mCnt = 0; else if (send) mCnt++;
    if (send) begin
      if (mLeft != 0) begin mOut = mByte[7]; mByte = mByte << 1; mLeft--; end
      else if (take) begin mOut = d[7]; mByte = d << 1; mLeft = 7; end
      else mOut = 0;
    end
    if (starve) mUf = 1; else if (clr) mUf = 0;
    mStall = oh;
    if (fs) mRun = 1;
    @(posedge clk); #1;
    chk(req, "serOut", int'(serOut), int'(mOut));
    chk(req, "frameBitCnt", int'(frameBitCnt), mCnt);
    chk(starve ? "R7" : "R8", "underflow", int'(underflow), int'(mUf));
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int sent;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "serOut", int'(serOut), 0);
    chk("R1", "underflow", int'(underflow), 0);
    chk("R1", "inReady", int'(inReady), 0);
    chk("R1", "frameBitCnt", int'(frameBitCnt), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "frameBitCnt after release", int'(frameBitCnt), 0);

    // R2 idle before first strobe, with busy inputs
    for (int i = 0; i < 12; i++) step(0, i[1], 1, 8'hFF, 0);

    // R3 start, then R4 MSB-first known pattern, R5 stall mid byte
    step(1, 0, 1, 8'hA5, 0);
    step(0, 0, 1, 8'hA5, 0);
    step(0, 1, 1, 8'h3C, 0);
    step(0, 0, 1, 8'h3C, 0);
    for (int i = 0; i < 14; i++) step(0, 0, 1, 8'h3C, 0);
    // R7 underflow then R8 clear
    for (int i = 0; i < 10; i++) step(0, 0, 0, 8'h00, 0);
    step(0, 0, 0, 8'h00, 1);   // clear loses to new underflow
    step(1, 0, 0, 8'h00, 1);   // boundary edge, no send: clear wins
    step(0, 0, 1, 8'h81, 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 200) == 0, ($urandom % 20) == 0, ($urandom % 8) != 0,
           8'($urandom), ($urandom % 50) == 0);

    // R9 full frame with framer-like overhead spacing
    step(1, 0, 1, 8'h5A, 1);
    sent = 0;
    while (sent < 4704) begin
      bit oh;
      oh = ((sent % 84) == 83) && !mStall;
      if (mRun && !mStall) sent++;
      step(0, oh, 1, 8'($urandom), 0);
    end
    chk("R9", "bits per frame", int'(frameBitCnt), 4704);
    step(1, 0, 1, 8'h00, 0);
    chk("R9", "restart after frame", int'(frameBitCnt), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule